// File: doc/BRIEF.md
# Conditional Branch Resolver

This block takes one 16-bit compressed-instruction halfword, the program counter that already points past it (halfword address plus two), and the four condition flags N, Z, C and V. It decides whether the halfword is a conditional branch, evaluates its condition against the flags, forms the branch destination and picks the address execution continues from.

The destination is the doubled, sign-extended 8-bit displacement plus a fixed pipeline adjustment of two, added to the incoming PC. If the condition fails, or the halfword is not a conditional branch, the next address is the incoming PC unchanged. Condition values 14 and 15 under the branch prefix are reported as illegal and never taken. When the `REG_OUT` parameter is 1 (the default), all outputs pass through one register stage and appear one clock after their inputs. When it is 0, the block is purely combinational.

Top module: `brcond_resolver`

## Requirements
- R1: A halfword counts as a conditional branch only when bits [15:12] equal 4'hD. Any other prefix gives taken = 0, illegal = 0 and next PC equal to the incoming PC.
- R2: With prefix 4'hD and condition field bits [11:8] equal to 4'hE or 4'hF, illegalCond is 1, taken is 0 and the next PC is the incoming PC.
- R3: The target equals PC + (sign-extended bits [7:0] shifted left by one) + 2, wrapping modulo 2^32. It is computed whatever the condition outcome.
- R4: Conditions 0 to 7 test a single flag, set then clear: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R5: Condition 8 passes when C=1 and Z=0. Condition 9 passes when C=0 or Z=1.
- R6: Condition 10 (4'hA) passes when N equals V. Condition 11 (4'hB) passes when N differs from V.
- R7: Condition 12 (4'hC) passes when Z=0 and N equals V. Condition 13 (4'hD) passes when Z=1 or N differs from V.
- R8: The next PC equals the target when taken and the incoming PC otherwise.
- R9: With REG_OUT = 1, outputs reflect the inputs sampled at the previous rising clock edge. While the active-low reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low reset of the output stage |
| instrWord | input | 16 | Fetched halfword |
| pcNow | input | 32 | Halfword address plus two |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| flagV | input | 1 | Overflow flag |
| branchTaken | output | 1 | Branch condition passed on a legal branch |
| branchTarget | output | 32 | Computed destination address |
| nextPc | output | 32 | Address execution continues from |
| illegalCond | output | 1 | Branch prefix with a reserved condition |

## Verification
The hardest cases to reach are address wrap-around and the extreme displacements. These are a PC near 2^32 with a maximal forward displacement, and a PC near zero with the most negative displacement, where the +2 adjustment carries across the boundary. The stimulus sweeps every condition value against all sixteen flag combinations for displacements 8'h00, 8'h7F, 8'h80 and 8'hFF. It places the PC at both ends of the address space, so each condition value is seen both taken and not taken at each wrap point. Halfwords with other prefixes and the two reserved conditions are applied with flag values that would make an ordinary condition pass.

// File: rtl/brres_pkg.sv
package brres_pkg;

  localparam int INSTR_W  = 16;
  localparam int ADDR_W   = 32;
  localparam int DISP_W   = 8;
  localparam int COND_W   = 4;
  localparam logic [3:0] BRANCH_PREFIX = 4'hD;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flagSet_t;

  // strobes from control to datapath
  typedef struct packed {
    logic isBranch;
    logic condPass;
    logic illegal;
    logic take;
  } ctrlStrobes_t;

endpackage

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   instrHigh,
  input  flagSet_t     flags,
  output ctrlStrobes_t strobes
);

  localparam int BASE_CNT = 8;

  logic [3:0] prefix;
  logic [COND_W-1:0] condCode;
  logic [BASE_CNT-1:0] baseTest;
  logic nEqV;
  logic reserved;
  logic passRaw;

  assign prefix   = instrHigh[7:4];
  assign condCode = instrHigh[3:0];
  assign nEqV     = (flags.n == flags.v);

  // Even condition values test a base predicate, odd values its inverse.
  always_comb begin
    baseTest    = '0;
    baseTest[0] = flags.z;
    baseTest[1] = flags.c;
    baseTest[2] = flags.n;
    baseTest[3] = flags.v;
    baseTest[4] = flags.c & ~flags.z;
    baseTest[5] = nEqV;
    baseTest[6] = ~flags.z & nEqV;
    baseTest[7] = 1'b0;
  end

  assign reserved = (condCode[3:1] == 3'b111);
  assign passRaw  = baseTest[condCode[3:1]] ^ condCode[0];

  always_comb begin
    strobes.isBranch = (prefix == BRANCH_PREFIX);
    strobes.illegal  = strobes.isBranch & reserved;
    strobes.condPass = ~reserved & passRaw;
    strobes.take     = strobes.isBranch & strobes.condPass;
  end

  p_illegal_blocks_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.illegal |-> !strobes.take);

  p_prefix_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (instrHigh[7:4] != 4'hD) |-> (!strobes.take && !strobes.illegal));

  p_zero_cond_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instrHigh == 8'hD0) |-> (strobes.take == flags.z));

  p_signed_ge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instrHigh == 8'hDA) |-> (strobes.take == !(flags.n ^ flags.v)));

endmodule

// File: rtl/brres_datapath.sv
module brres_datapath
  import brres_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] pcIn,
  input  ctrlStrobes_t      strobes,
  output logic              takenOut,
  output logic              illegalOut,
  output logic [ADDR_W-1:0] targetOut,
  output logic [ADDR_W-1:0] nextOut
);

  localparam int EXT_W = ADDR_W - DISP_W - 1;
  localparam logic [ADDR_W-1:0] PIPE_ADJ = ADDR_W'(2);

  logic [ADDR_W-1:0] dispScaled;
  logic [ADDR_W-1:0] targetComb;
  logic [ADDR_W-1:0] nextComb;

  assign dispScaled = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};
  assign targetComb = pcIn + dispScaled + PIPE_ADJ;
  assign nextComb   = strobes.take ? targetComb : pcIn;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          takenOut   <= 1'b0;
          illegalOut <= 1'b0;
          targetOut  <= '0;
          nextOut    <= '0;
        end else begin
          takenOut   <= strobes.take;
          illegalOut <= strobes.illegal;
          targetOut  <= targetComb;
          nextOut    <= nextComb;
        end
      end
    end else begin : g_comb
      always_comb begin
        takenOut   = strobes.take;
        illegalOut = strobes.illegal;
        targetOut  = targetComb;
        nextOut    = nextComb;
      end
    end
  endgenerate

  p_offset_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(targetComb - pcIn) >= -254) && ($signed(targetComb - pcIn) <= 256));

  p_even_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (targetComb[0] == pcIn[0]));

  p_fallthrough_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |-> (nextComb == pcIn));

endmodule

// File: rtl/brcond_resolver.sv
module brcond_resolver
  import brres_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] instrWord,
  input  logic [31:0] pcNow,
  input  logic        flagN,
  input  logic        flagZ,
  input  logic        flagC,
  input  logic        flagV,
  output logic        branchTaken,
  output logic [31:0] branchTarget,
  output logic [31:0] nextPc,
  output logic        illegalCond
);

  flagSet_t     flagsIn;
  ctrlStrobes_t strobes;

  assign flagsIn = '{n: flagN, z: flagZ, c: flagC, v: flagV};

  brres_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .instrHigh (instrWord[15:8]),
    .flags     (flagsIn),
    .strobes   (strobes)
  );

  brres_datapath #(.REG_OUT(REG_OUT)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .disp       (instrWord[7:0]),
    .pcIn       (pcNow),
    .strobes    (strobes),
    .takenOut   (branchTaken),
    .illegalOut (illegalCond),
    .targetOut  (branchTarget),
    .nextOut    (nextPc)
  );

  p_taken_selects_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (nextPc == branchTarget));

endmodule

// File: tb/test_brcond_resolver.sv
module test_brcond_resolver;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord = 16'h0000;
  logic [31:0] pcNow = 32'h0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagC = 1'b0, flagV = 1'b0;
  logic        branchTaken, illegalCond;
  logic [31:0] branchTarget, nextPc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brcond_resolver i_brcond_resolver (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .pcNow(pcNow),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .nextPc(nextPc), .illegalCond(illegalCond)
  );

  function automatic bit condExp(input logic [3:0] cc, input logic n, z, c, v);
    case (cc)
      4'h0: return z;            4'h1: return !z;
      4'h2: return c;            4'h3: return !c;
      4'h4: return n;            4'h5: return !n;
      4'h6: return v;            4'h7: return !v;
      4'h8: return c && !z;      4'h9: return !c || z;
      4'hA: return n == v;       4'hB: return n != v;
      4'hC: return !z && n == v; 4'hD: return z || n != v;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string condTag(input logic [15:0] w);
    if (w[15:12] != 4'hD) return "R1";
    if (w[11:8] >= 4'hE)  return "R2";
    if (w[11:8] <= 4'h7)  return "R4";
    if (w[11:8] <= 4'h9)  return "R5";
    if (w[11:8] <= 4'hB)  return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [31:0] pc, input logic [3:0] nzcv);
    logic isBr, resv, tk;
    logic [31:0] tgt;
    @(negedge clk);
    instrWord = w; pcNow = pc;
    {flagN, flagZ, flagC, flagV} = nzcv;
    isBr = (w[15:12] == 4'hD);
    resv = isBr && (w[11:8] >= 4'hE);
    tk   = isBr && !resv && condExp(w[11:8], nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
    tgt  = pc + {{23{w[7]}}, w[7:0], 1'b0} + 32'd2;
    @(negedge clk);  // one register stage (R9)
    check(condTag(w), "taken", {31'b0, branchTaken}, {31'b0, tk});
    check(resv ? "R2" : "R1", "illegal", {31'b0, illegalCond}, {31'b0, resv});
    check("R3", "target", branchTarget, tgt);
    check("R8", "nextPc", nextPc, tk ? tgt : pc);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [4];
    logic [31:0] pcs [4];
    offs[0] = 8'h00; offs[1] = 8'h7F; offs[2] = 8'h80; offs[3] = 8'hFF;
    pcs[0] = 32'hFFFF_FFFE; pcs[1] = 32'h0000_0002;
    pcs[2] = 32'h0000_1000; pcs[3] = 32'h8000_0000;

    instrWord = 16'hD07F; pcNow = 32'h1234; flagZ = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset clears every output
    check("R9", "reset taken", {31'b0, branchTaken}, 32'd0);
    check("R9", "reset illegal", {31'b0, illegalCond}, 32'd0);
    check("R9", "reset target", branchTarget, 32'd0);
    check("R9", "reset nextPc", nextPc, 32'd0);
    rstN = 1'b1;

    // Full sweep: conditions x flags x extreme displacements x wrap PCs
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        for (int o = 0; o < 4; o++)
          apply({4'hD, 4'(cc), offs[o]}, pcs[(cc + f + o) % 4], 4'(f));

    // R1: other prefixes with flags that would pass condition 0
    for (int p = 0; p < 16; p++)
      if (p != 13) apply({4'(p), 4'h0, 8'h10}, 32'h0000_2000, 4'b0100);

    // R3: wrap-around targets
    apply(16'hD07F, 32'hFFFF_FF10, 4'b0100);   // forward past 2^32
    apply(16'hD180, 32'h0000_0004, 4'b0000);   // backward below 0

    // R9: back-to-back change, output follows by exactly one edge
    @(negedge clk);
    instrWord = 16'hD005; pcNow = 32'h100; {flagN, flagZ, flagC, flagV} = 4'b0100;
    @(posedge clk); #1;
    instrWord = 16'hD105;
    @(negedge clk);
    check("R9", "first edge taken", {31'b0, branchTaken}, 32'd1);
    @(negedge clk);
    check("R9", "second edge taken", {31'b0, branchTaken}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule